// File: doc/BRIEF.md
# Elevator Car Controller with Fire Override

This block is the motion and door sequencer for a single elevator car. Each cycle it compares a requested floor, already chosen elsewhere, against the floor the car is at. From that comparison it drives the up and down motion commands and the door-open command. While the door is open, it counts tick pulses so that the door stays open for a minimum interval. It also raises a flag that tells the outside world a door hold is in progress.

Normal operation is one sub-machine inside a two-level machine. A fire alarm input takes priority over every normal state. The alarm sends the car down to floor 1 and leaves it parked there with the door open. Normal service resumes only after the car has reached floor 1 and the alarm has cleared.

All outputs are a pure function of the registered state (Moore style), so no input reaches an output in the same cycle. Floors are unsigned numbers, and floor 1 is the value 1.

Top module: `elev_ctrl`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, the machine is in the rest state, and {up, down, door_open, timer_start} reads 0,0,1,0.
- R2: The outputs {up, down, door_open, timer_start} depend only on the state: rest 0,0,1,0; ascending 1,0,0,0; descending 0,1,0,0; door hold 0,0,1,1; fire descent 0,1,0,0; fire parked 0,0,1,0.
- R3: From rest, with fire low, the machine moves to ascending when req_floor > cur_floor, to descending when req_floor < cur_floor, and stays at rest when they are equal.
- R4: With fire low, ascending persists while req_floor > cur_floor and otherwise moves to door hold. Descending persists while req_floor < cur_floor and otherwise moves to door hold.
- R5: The hold counter starts at zero on entry to door hold and adds one per cycle in which tick is high. Door hold returns to rest on the first edge at which the count already equals DOOR_TICKS. With tick always high, timer_start is therefore high for exactly DOOR_TICKS+1 cycles. Ticks outside door hold have no effect.
- R6: door_open is never 1 while up or down is 1, and up and down are never 1 together.
- R7: With fire high in any normal state (rest, ascending, descending, door hold), the next state is fire descent if cur_floor > 1, and fire parked otherwise. This takes priority over every normal transition.
- R8: Fire descent persists while cur_floor > 1, whatever the level of fire, and moves to fire parked once cur_floor is not above 1.
- R9: Fire parked stays while fire is high and returns to rest on the first edge with fire low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_floor | input | FLOOR_W | Resolved target floor, unsigned |
| cur_floor | input | FLOOR_W | Floor the car is at, unsigned, floor 1 = 1 |
| fire | input | 1 | Fire emergency flag |
| tick | input | 1 | One-cycle time-base pulse for the door counter |
| up | output | 1 | Move car upward |
| down | output | 1 | Move car downward |
| door_open | output | 1 | Hold the door open |
| timer_start | output | 1 | High during the normal door hold interval |

## Verification
The bound checker watches five things on every cycle: the exclusion between door and motion (R6), entry into the fire sequence (R7), the persistence of fire descent (R8), holding in and leaving the parked state (R9), and the rest-to-ascending step (R3). It also checks that a door hold only ends after the counter has reached its limit (R5). Other behaviour needs full input sequences, so only the bench's scenarios can show it. This covers the exact length of the door hold under gapped ticks, the complete sweep of every request and floor pair from rest, and the state reached when fire preempts each normal state at every floor. The bench also confirms that the car returns to rest only after the alarm clears.

// File: rtl/elev_pkg.sv
package elev_pkg;

  typedef enum logic [2:0] {
    CAR_REST   = 3'd0,
    CAR_ASCEND = 3'd1,
    CAR_DESC   = 3'd2,
    CAR_HOLD   = 3'd3,
    CAR_FDESC  = 3'd4,
    CAR_FPARK  = 3'd5
  } car_state_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic open;
    logic tstart;
  } car_cmd_t;

  // Moore output map: one entry per state
  function automatic car_cmd_t cmd_of(car_state_e s);
    car_cmd_t c;
    c = '{up: 1'b0, dn: 1'b0, open: 1'b0, tstart: 1'b0};
    unique case (s)
      CAR_REST:   c.open = 1'b1;
      CAR_ASCEND: c.up   = 1'b1;
      CAR_DESC:   c.dn   = 1'b1;
      CAR_HOLD:   begin c.open = 1'b1; c.tstart = 1'b1; end
      CAR_FDESC:  c.dn   = 1'b1;
      CAR_FPARK:  c.open = 1'b1;
      default:    c.open = 1'b1;
    endcase
    return c;
  endfunction

  function automatic logic in_fire_branch(car_state_e s);
    return (s == CAR_FDESC) || (s == CAR_FPARK);
  endfunction

endpackage

// File: rtl/elev_floor_cmp.sv
module elev_floor_cmp #(
  parameter int FLOOR_W = 4
) (
  input  logic [FLOOR_W-1:0] req_floor,
  input  logic [FLOOR_W-1:0] cur_floor,
  output logic               req_above,
  output logic               req_below,
  output logic               over_ground
);
  localparam logic [FLOOR_W-1:0] GROUND = FLOOR_W'(1);

  always_comb begin
    req_above   = req_floor > cur_floor;
    req_below   = req_floor < cur_floor;
    over_ground = cur_floor > GROUND;
  end
endmodule

// File: rtl/elev_door_timer.sv
module elev_door_timer #(
  parameter int DOOR_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_hold,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(DOOR_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DOOR_TICKS);

  logic [CW-1:0] count_q;

  assign expired = (count_q >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!in_hold) begin
      count_q <= '0;
    end else if (tick && !expired) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/elev_seq.sv
module elev_seq
  import elev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       req_above,
  input  logic       req_below,
  input  logic       over_ground,
  input  logic       hold_expired,
  output car_state_e state
);
  car_state_e next_state;
  car_state_e fire_entry;

  assign fire_entry = over_ground ? CAR_FDESC : CAR_FPARK;

  always_comb begin
    next_state = state;
    unique case (state)
      CAR_REST: begin
        if (fire)           next_state = fire_entry;
        else if (req_above) next_state = CAR_ASCEND;
        else if (req_below) next_state = CAR_DESC;
        else                next_state = CAR_REST;
      end
      CAR_ASCEND: begin
        if (fire)           next_state = fire_entry;
        else if (req_above) next_state = CAR_ASCEND;
        else                next_state = CAR_HOLD;
      end
      CAR_DESC: begin
        if (fire)           next_state = fire_entry;
        else if (req_below) next_state = CAR_DESC;
        else                next_state = CAR_HOLD;
      end
      CAR_HOLD: begin
        if (fire)              next_state = fire_entry;
        else if (hold_expired) next_state = CAR_REST;
        else                   next_state = CAR_HOLD;
      end
      CAR_FDESC: begin
        if (over_ground) next_state = CAR_FDESC;
        else             next_state = CAR_FPARK;
      end
      CAR_FPARK: begin
        if (fire) next_state = CAR_FPARK;
        else      next_state = CAR_REST;
      end
      default: next_state = CAR_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CAR_REST;
    else        state <= next_state;
  end
endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl
  import elev_pkg::*;
#(
  parameter int FLOOR_W    = 4,
  parameter int DOOR_TICKS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLOOR_W-1:0] req_floor,
  input  logic [FLOOR_W-1:0] cur_floor,
  input  logic               fire,
  input  logic               tick,
  output logic               up,
  output logic               down,
  output logic               door_open,
  output logic               timer_start
);
  logic       req_above;
  logic       req_below;
  logic       over_ground;
  logic       door_done;
  logic       fire_mode;
  logic       in_hold;
  car_state_e state;
  car_cmd_t   cmd;

  elev_floor_cmp #(.FLOOR_W(FLOOR_W)) u_cmp (
    .req_floor  (req_floor),
    .cur_floor  (cur_floor),
    .req_above  (req_above),
    .req_below  (req_below),
    .over_ground(over_ground)
  );

  elev_door_timer #(.DOOR_TICKS(DOOR_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_hold(in_hold),
    .tick   (tick),
    .expired(door_done)
  );

  elev_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .req_above   (req_above),
    .req_below   (req_below),
    .over_ground (over_ground),
    .hold_expired(door_done),
    .state       (state)
  );

  assign in_hold     = (state == CAR_HOLD);
  assign fire_mode   = in_fire_branch(state);
  assign cmd         = cmd_of(state);
  assign up          = cmd.up;
  assign down        = cmd.dn;
  assign door_open   = cmd.open;
  assign timer_start = cmd.tstart;
endmodule

// File: rtl/elev_ctrl_chk.sv
module elev_ctrl_chk #(
  parameter int FLOOR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FLOOR_W-1:0] req_floor,
  input logic [FLOOR_W-1:0] cur_floor,
  input logic               fire,
  input logic               up,
  input logic               down,
  input logic               door_open,
  input logic               timer_start,
  input logic               fire_mode,
  input logic               door_done
);
  localparam logic [FLOOR_W-1:0] GROUND = FLOOR_W'(1);

  p_open_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    door_open |-> (!up && !down));

  p_dir_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && down));

  p_idle_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (door_open && !timer_start && !fire_mode && !fire && (req_floor > cur_floor)) |=> up);

  p_door_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(timer_start) && !$past(fire)) |-> $past(door_done));

  p_fire_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_mode && fire) |=> fire_mode);

  p_fire_descend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_mode && down && (cur_floor > GROUND)) |=> (fire_mode && down));

  p_fire_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_mode && fire) |=> fire_mode);

  p_fire_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_mode && door_open && !fire) |=> (!fire_mode && door_open));
endmodule

bind elev_ctrl elev_ctrl_chk #(.FLOOR_W(FLOOR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_floor  (req_floor),
  .cur_floor  (cur_floor),
  .fire       (fire),
  .up         (up),
  .down       (down),
  .door_open  (door_open),
  .timer_start(timer_start),
  .fire_mode  (fire_mode),
  .door_done  (door_done)
);

// File: tb/tb_elev_ctrl.sv
`timescale 1ns/1ps
module tb_elev_ctrl;
  localparam int W  = 3;
  localparam int DT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] req_floor = '0;
  logic [W-1:0] cur_floor = '0;
  logic         fire = 1'b0;
  logic         tick = 1'b0;
  logic         up, down, door_open, timer_start;

  int checks = 0;
  int failures = 0;
  int m_st = 0;   // 0 rest,1 asc,2 desc,3 hold,4 fire desc,5 fire park
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  elev_ctrl #(.FLOOR_W(W), .DOOR_TICKS(DT)) dut (
    .clk(clk), .rst_n(rst_n), .req_floor(req_floor), .cur_floor(cur_floor),
    .fire(fire), .tick(tick), .up(up), .down(down), .door_open(door_open),
    .timer_start(timer_start)
  );

  function automatic logic [3:0] exp_cmd(int s);
    case (s)
      1: return 4'b1000;
      2: return 4'b0100;
      3: return 4'b0011;
      4: return 4'b0100;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string tag);
    logic [3:0] act;
    act = {up, down, door_open, timer_start};
    check_val({tag, "/R2 cmd"}, act, exp_cmd(m_st));
    check_val("R6 exclusion", int'((door_open && (up || down)) || (up && down)), 0);
  endtask

  task automatic step(input int r, input int f, input logic fi, input logic tk);
    int nst;
    string tag;
    req_floor = W'(r); cur_floor = W'(f); fire = fi; tick = tk;
    @(posedge clk);
    nst = m_st;
    tag = "R3";
    case (m_st)
      0: begin tag = "R3"; if (r > f) nst = 1; else if (r < f) nst = 2; end
      1: begin tag = "R4"; nst = (r > f) ? 1 : 3; end
      2: begin tag = "R4"; nst = (r < f) ? 2 : 3; end
      3: begin tag = "R5"; if (m_cnt >= DT) nst = 0; end
      4: begin tag = "R8"; nst = (f > 1) ? 4 : 5; end
      default: begin tag = "R9"; nst = fi ? 5 : 0; end
    endcase
    if (fi && m_st <= 3) begin tag = "R7"; nst = (f > 1) ? 4 : 5; end
    if (m_st != 3) m_cnt = 0;
    else if (tk && m_cnt < DT) m_cnt++;
    m_st = nst;
    #1;
    check_outputs(tag);
    @(negedge clk);
  endtask

  task automatic settle(input int f);
    for (int k = 0; k < DT + 4; k++) step(f, f, 1'b0, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    cur_floor = W'(1); req_floor = W'(3); fire = 1'b1; tick = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 reset cmd", {up, down, door_open, timer_start}, 4'b0010);
    rst_n = 1'b1;
    m_st = 0; m_cnt = 0;
    step(1, 1, 1'b0, 1'b1);   // R1: first edge stays at rest
    check_val("R1 rest after reset", {up, down, door_open, timer_start}, 4'b0010);

    // R3/R4: every request/floor pair from rest
    for (int f = 0; f < 8; f++) begin
      for (int r = 0; r < 8; r++) begin
        settle(f);
        step(r, f, 1'b0, 1'b0);
        step(r, f, 1'b0, 1'b1);
        step(r, r, 1'b0, 1'b1);
        step(r, r, 1'b0, 1'b0);
      end
    end

    // R5: hold length with tick every cycle
    settle(2);
    step(5, 2, 1'b0, 1'b1);
    step(5, 5, 1'b0, 1'b1);
    n = 1;
    while (timer_start && n < 50) begin
      step(5, 5, 1'b0, 1'b1);
      if (timer_start) n++;
    end
    check_val("R5 hold cycles tick every cycle", n, DT + 1);

    // R5: hold length with tick every third cycle
    settle(4);
    step(1, 4, 1'b0, 1'b1);
    step(1, 1, 1'b0, 1'b1);
    n = 1;
    for (int k = 1; k < 100 && timer_start; k++) begin
      step(1, 1, 1'b0, (k % 3) == 0);
      if (timer_start) n++;
    end
    check_val("R5 hold cycles gapped ticks", n, 3 * DT + 1);

    // R7/R8/R9: fire from every normal state at every floor
    for (int f = 0; f < 8; f++) begin
      for (int mode = 0; mode < 4; mode++) begin
        settle(f);
        if (mode == 1 && f < 7) step(7, f, 1'b0, 1'b1);
        if (mode == 2 && f > 0) step(0, f, 1'b0, 1'b1);
        if (mode == 3 && f < 7) begin
          step(7, f, 1'b0, 1'b1);
          step(f, f, 1'b0, 1'b1);
        end
        step(3, f, 1'b1, 1'b1);
        check_val("R7 fire entry", {up, down, door_open, timer_start},
                  (f > 1) ? 4'b0100 : 4'b0010);
        for (int fl = f; fl > 1; fl--) begin
          step(6, fl, (fl % 2) == 0, 1'b1);   // R8: fire toggling, still descends
          check_val("R8 descent held", down, 1);
        end
        step(6, 1, 1'b1, 1'b1);
        step(6, 1, 1'b1, 1'b1);
        check_val("R9 parked while fire", {up, down, door_open, timer_start}, 4'b0010);
        step(6, 1, 1'b0, 1'b1);
        step(6, 1, 1'b0, 1'b1);
        check_val("R9 resumes normal", up, 1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule